// File: doc/BRIEF.md
# Serial Flash Continuous-Read Target

This block is a synthesizable serial-peripheral target that answers the continuous array read of a page-organised serial flash. A host lowers the chip-select line and shifts in a one-byte read command, then a 24-bit address, then a fixed run of don't-care bits. From then on the target returns array bytes, most significant bit first, for as long as chip select stays low. An internal counter walks through each page. Pages have a length that need not be a power of two (264 bytes by default). The counter moves on to the next page without a gap, and it returns from the last page to page 0.

The chip-select, clock and data lines are brought into the system clock domain by a synchronizer of parameterised depth. Clock edges are found by comparing samples, so the serial clock may idle low or idle high. The array is deliberately small: its page count is a parameter. It is filled through a separate single-cycle backdoor write port. The serial output comes as a data bit plus an output-enable. The enable low means the pin is released to high impedance.

An unknown command byte makes the target ignore the rest of the frame. Raising chip select ends any frame at once.

Top module: `sflash_stream_tgt`

## Requirements
- R1: Command byte 8'h68 or 8'hE8 starts a read. Any other command byte leaves `so_en` low until chip select rises, whatever follows.
- R2: Command, address and data bits are all carried most significant bit first. Input bits are taken on rising serial-clock edges.
- R3: Address bit layout:
  - bits 23:21 are reserved and ignored;
  - bits 20:9 are the page number, of which only the low log2(PAGES) bits are used;
  - bits 8:0 are the byte offset, and an offset of PAGE_BYTES or more is treated as PAGE_BYTES-1.
- R4: After the address, exactly DUMMY_BITS (32) bits are clocked in with `so_en` low. The first data bit (bit 7 of the addressed byte) appears on `so_d` with `so_en` high after the falling edge that follows the last dummy bit. Each later falling edge presents the next bit.
- R5: After byte PAGE_BYTES-1 of a page, the next byte is byte 0 of the following page, with no extra clocks.
- R6: After the last byte of page PAGES-1, the next byte is byte 0 of page 0, with no extra clocks.
- R7: Raising chip select at any point drives `so_en` low. The next frame decodes from its own command byte, unaffected by the aborted one.
- R8: Serial-clock idle low (mode 0) and idle high (mode 3) give identical data for the same command and address.
- R9: A backdoor write with `bd_we` high stores `bd_data` at array index page*PAGE_BYTES+offset. A later read returns it.
- R10: After reset, `so_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data into the target |
| so_d | output | 1 | Serial data out of the target |
| so_en | output | 1 | Output enable for so_d; low means high impedance |
| bd_we | input | 1 | Backdoor array write strobe |
| bd_addr | input | AW | Backdoor array index, page*PAGE_BYTES+offset |
| bd_data | input | 8 | Backdoor write byte |

## Verification
The embedded properties assume that the serial clock toggles slowly against `clk`. Each serial-clock level must last several system cycles, so every edge is seen once after the synchronizer. The properties also assume that the first serial-clock rise comes some cycles after chip select falls. The bench holds every serial-clock phase for eight system cycles and changes the data input only while the clock is low. It waits a full phase after moving chip select and never changes the clock and chip select in the same cycle. The sweep reads from many start offsets across all pages, in both clock polarities and with both command bytes.

// File: rtl/sft_pkg.sv
package sft_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA,
      ST_IGN
   } sft_state_e;

   localparam int CMD_BITS   = 8;
   localparam int ADDR_BITS  = 24;
   localparam int OFF_FIELD  = 9;
   localparam int PAGE_FIELD = 12;
endpackage

// File: rtl/sft_sync.sv
module sft_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sft_array.sv
module sft_array #(
   parameter int DEPTH = 1056,
   parameter int AW    = 11
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] ram [DEPTH];

   always_ff @(posedge clk) begin
      if (we) ram[waddr] <= wdata;
   end

   assign rdata = ram[raddr];
endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
   import sft_pkg::*;
#(
   parameter int         PAGES      = 4,
   parameter int         PAGE_BYTES = 264,
   parameter int         DUMMY_BITS = 32,
   parameter logic [7:0] OP_A       = 8'h68,
   parameter logic [7:0] OP_B       = 8'hE8,
   parameter int         AW         = 11,
   localparam int        PW         = $clog2(PAGES),
   localparam int        OW         = $clog2(PAGE_BYTES),
   localparam int        CW         = $clog2((DUMMY_BITS > ADDR_BITS) ? DUMMY_BITS : ADDR_BITS) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          sck_s,
   input  logic          si_s,
   input  logic [7:0]    rdata,
   output logic [AW-1:0] raddr,
   output logic          so_d,
   output logic          so_en
);
   localparam logic [OW-1:0] LAST_OFF = OW'(PAGE_BYTES - 1);

   sft_state_e    state;
   logic          sck_q;
   logic [CW-1:0] cnt;
   logic [22:0]   sh;
   logic [23:0]   sh_nxt;
   logic [PW-1:0] page;
   logic [OW-1:0] off;
   logic [7:0]    obuf;
   logic [2:0]    bidx;
   logic          rise, fall;
   logic [OW-1:0] off_in;
   logic          unused_addr;

   assign rise   = sck_s & ~sck_q;
   assign fall   = ~sck_s & sck_q;
   assign sh_nxt = {sh, si_s};
   assign raddr  = AW'(int'(page) * PAGE_BYTES + int'(off));
   assign unused_addr = ^{sh_nxt[23:21], sh_nxt[20:9]};

   generate
      if (PAGE_BYTES == (1 << OFF_FIELD)) begin : g_off_full
         assign off_in = OW'(sh_nxt[OFF_FIELD-1:0]);
      end else begin : g_off_clamp
         assign off_in = (int'(sh_nxt[OFF_FIELD-1:0]) >= PAGE_BYTES) ?
                         LAST_OFF : OW'(sh_nxt[OFF_FIELD-1:0]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sck_q <= 1'b0;
         cnt   <= '0;
         sh    <= '0;
         page  <= '0;
         off   <= '0;
         obuf  <= '0;
         bidx  <= '0;
         so_d  <= 1'b0;
         so_en <= 1'b0;
      end else begin
         sck_q <= sck_s;
         if (cs_s) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            so_en <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  state <= ST_OPC;
                  cnt   <= '0;
               end
               ST_OPC: if (rise) begin
                  sh <= sh_nxt[22:0];
                  if (cnt == CW'(CMD_BITS - 1)) begin
                     cnt   <= '0;
                     state <= (sh_nxt[7:0] == OP_A || sh_nxt[7:0] == OP_B) ?
                              ST_ADDR : ST_IGN;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ADDR: if (rise) begin
                  sh <= sh_nxt[22:0];
                  if (cnt == CW'(ADDR_BITS - 1)) begin
                     cnt   <= '0;
                     page  <= sh_nxt[OFF_FIELD +: PW];
                     off   <= off_in;
                     state <= ST_DUMMY;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DUMMY: if (rise) begin
                  if (cnt == CW'(DUMMY_BITS - 1)) begin
                     cnt   <= '0;
                     bidx  <= '0;
                     state <= ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: if (fall) begin
                  so_en <= 1'b1;
                  bidx  <= bidx + 1'b1;
                  if (bidx == 3'd0) begin
                     obuf <= rdata;
                     so_d <= rdata[7];
                     if (off == LAST_OFF) begin
                        off  <= '0;
                        page <= page + 1'b1;
                     end else begin
                        off <= off + 1'b1;
                     end
                  end else begin
                     so_d <= obuf[3'd7 - bidx];
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R7: chip select high silences the output on the next cycle
   a_r7_cs_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !so_en);

   // R1: a rejected command never drives the pin
   a_r1_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGN) |-> !so_en);

   // R4: the output is only enabled in the data phase
   a_r4_data_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
      so_en |-> (state == ST_DATA));

   // R3: the byte counter never leaves the page
   a_r3_offset_in_page: assert property (@(posedge clk) disable iff (!rst_n)
      int'(off) < PAGE_BYTES);

   // R5 / R6: last byte of a page rolls to byte 0 of the next page, modulo PAGES
   a_r5_page_roll: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && state == ST_DATA && fall && bidx == 3'd0 && off == LAST_OFF)
      |=> (off == '0 && page == PW'($past(page) + 1'b1)));
endmodule

// File: rtl/sflash_stream_tgt.sv
module sflash_stream_tgt
   import sft_pkg::*;
#(
   parameter int         PAGES       = 4,
   parameter int         PAGE_BYTES  = 264,
   parameter int         DUMMY_BITS  = 32,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] OP_A        = 8'h68,
   parameter logic [7:0] OP_B        = 8'hE8,
   localparam int        DEPTH       = PAGES * PAGE_BYTES,
   localparam int        AW          = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          sck,
   input  logic          si,
   output logic          so_d,
   output logic          so_en,
   input  logic          bd_we,
   input  logic [AW-1:0] bd_addr,
   input  logic [7:0]    bd_data
);
   initial begin
      a_cfg_pages: assert (PAGES >= 2 && PAGES <= (1 << PAGE_FIELD) && (PAGES & (PAGES - 1)) == 0)
         else $error("PAGES must be a power of two between 2 and 4096");
      a_cfg_page_bytes: assert (PAGE_BYTES >= 2 && PAGE_BYTES <= (1 << OFF_FIELD))
         else $error("PAGE_BYTES must lie in 2..512");
      a_cfg_dummy: assert (DUMMY_BITS >= 1)
         else $error("DUMMY_BITS must be at least 1");
   end

   logic [2:0]    sync_q;
   logic [AW-1:0] raddr;
   logic [7:0]    rdata;

   sft_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, si}),
      .q     (sync_q)
   );

   sft_ctrl #(
      .PAGES      (PAGES),
      .PAGE_BYTES (PAGE_BYTES),
      .DUMMY_BITS (DUMMY_BITS),
      .OP_A       (OP_A),
      .OP_B       (OP_B),
      .AW         (AW)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_s  (sync_q[2]),
      .sck_s (sync_q[1]),
      .si_s  (sync_q[0]),
      .rdata (rdata),
      .raddr (raddr),
      .so_d  (so_d),
      .so_en (so_en)
   );

   sft_array #(
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_array (
      .clk   (clk),
      .we    (bd_we),
      .waddr (bd_addr),
      .wdata (bd_data),
      .raddr (raddr),
      .rdata (rdata)
   );

   // R10: output disabled coming out of reset
   a_r10_reset_quiet: assert property (@(posedge clk)
      $rose(rst_n) |-> !so_en);
endmodule

// File: tb/sim_sflash_stream_tgt.sv
module sim_sflash_stream_tgt;
   localparam int PAGES = 4;
   localparam int PB    = 264;
   localparam int NB    = PAGES * PB;
   localparam int AW    = $clog2(NB);
   localparam int H     = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          sck = 1'b0;
   logic          si = 1'b0;
   logic          so_d, so_en;
   logic          bd_we = 1'b0;
   logic [AW-1:0] bd_addr = '0;
   logic [7:0]    bd_data = '0;

   int         errs = 0;
   int         checks = 0;
   int         en_hits = 0;
   logic [7:0] model [NB];

   always #10 clk = ~clk;

   sflash_stream_tgt #(.PAGES(PAGES), .PAGE_BYTES(PB)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .so_d(so_d), .so_en(so_en),
      .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input bit b, output bit d);
      sck = 1'b0;
      si  = b;
      wclk(H);
      d = so_d;
      if (so_en) en_hits++;
      sck = 1'b1;
      wclk(H);
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         bit d;
         bit_io(v[i], d);
      end
   endtask

   task automatic start(input bit mode3);
      sck = mode3;
      wclk(H);
      cs_n = 1'b0;
      wclk(H);
      en_hits = 0;
   endtask

   task automatic stop(input bit mode3);
      if (!mode3) begin
         sck = 1'b0;
         wclk(H);
      end
      cs_n = 1'b1;
      wclk(H);
      chk(so_en == 1'b0, "R7 so_en after cs high", so_en, 0);
   endtask

   task automatic bd_write(input int idx, input logic [7:0] v);
      bd_we   = 1'b1;
      bd_addr = AW'(idx);
      bd_data = v;
      wclk(1);
      bd_we   = 1'b0;
      model[idx] = v;
   endtask

   task automatic read_chk(input logic [7:0] op, input int rsv, input int pg, input int of,
                           input int n, input int tail, input bit mode3, input string req);
      int p, o;
      start(mode3);
      send(32'(op), 8);
      send({8'h0, 3'(rsv), 12'(pg), 9'(of)}, 24);
      send(32'h0, 32);
      chk(en_hits == 0, {req, " R4 quiet before data"}, en_hits, 0);
      p = pg % PAGES;
      o = (of >= PB) ? PB - 1 : of;
      for (int k = 0; k < n; k++) begin
         logic [7:0] got;
         en_hits = 0;
         for (int b = 7; b >= 0; b--) begin
            bit d;
            bit_io(1'b0, d);
            got[b] = d;
         end
         chk(en_hits == 8, {req, " R4 so_en during data"}, en_hits, 8);
         chk(got == model[p * PB + o], {req, " R2 data byte"}, got, model[p * PB + o]);
         if (o == PB - 1) begin
            o = 0;
            p = (p + 1) % PAGES;
         end else begin
            o++;
         end
      end
      for (int t = 0; t < tail; t++) begin
         bit d;
         bit_io(1'b0, d);
      end
      stop(mode3);
   endtask

   task automatic ignore_chk(input logic [7:0] op, input bit mode3);
      start(mode3);
      send(32'(op), 8);
      send(32'h0001_0005, 24);
      send(32'h0, 32);
      send(32'h0, 16);
      chk(en_hits == 0, "R1 unknown command silent", en_hits, 0);
      stop(mode3);
   endtask

   initial begin
      wclk(5);
      chk(so_en == 1'b0, "R10 so_en in reset", so_en, 0);
      rst_n = 1'b1;
      wclk(4);
      chk(so_en == 1'b0, "R10 so_en after reset", so_en, 0);

      for (int i = 0; i < NB; i++) bd_write(i, 8'((i * 37) ^ (i >> 3) ^ 8'h5A));

      // R1 R2 R4 R9: basic read, mode 0, first command byte
      read_chk(8'h68, 0, 1, 5, 10, 0, 1'b0, "R1 mode0 68h");
      // R8: same address, mode 3, second command byte
      read_chk(8'hE8, 0, 1, 5, 10, 0, 1'b1, "R8 mode3 E8h");
      // R5: page roll
      read_chk(8'h68, 0, 0, 260, 8, 0, 1'b0, "R5 page roll");
      read_chk(8'hE8, 0, 2, 262, 4, 0, 1'b1, "R5 page roll mode3");
      // R6: array wrap
      read_chk(8'h68, 0, 3, 261, 6, 0, 1'b0, "R6 array wrap");
      // R3: clamp, reserved bits, high page bits
      read_chk(8'h68, 7, 2, 300, 3, 0, 1'b1, "R3 offset clamp");
      read_chk(8'hE8, 5, 12'hFD, 511, 2, 0, 1'b0, "R3 page field low bits");
      // R1: unknown commands
      ignore_chk(8'h0B, 1'b0);
      ignore_chk(8'h00, 1'b1);
      ignore_chk(8'hE9, 1'b0);
      // R7: abort mid-byte, then a fresh frame
      read_chk(8'h68, 0, 0, 10, 2, 3, 1'b0, "R7 abort");
      read_chk(8'h68, 0, 0, 40, 3, 0, 1'b0, "R7 fresh frame");
      // R9: backdoor rewrite then read back
      bd_write(2 * PB + 100, 8'hA5);
      bd_write(2 * PB + 101, 8'h3C);
      read_chk(8'hE8, 0, 2, 100, 2, 0, 1'b1, "R9 backdoor");
      // sweep of start points over all pages, both modes and both command bytes
      for (int s = 0; s < 8; s++) begin
         read_chk((s % 4 < 2) ? 8'h68 : 8'hE8, s % 8, s % PAGES, (s * 71 + 3) % PB,
                  5, 0, 1'(s % 2), "R8 sweep");
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule